// File: doc/BRIEF.md
# Resynchronizing Asynchronous Serial Receiver

This block turns an asynchronous serial line carrying 8N1 characters (one low start bit, eight data bits, one high stop bit, no parity) into parallel bytes. It times every bit from a baud enable that pulses at sixteen times the bit rate. The line is first passed through a synchronizer. A falling level starts a frame. The block checks the start bit again half a bit later, then samples each data bit and the stop bit at the middle of its bit period.

The frame sequencer looks for the next start edge as soon as it has sampled the middle of the stop bit. It does not wait for the nominal end of the stop bit, and it does not need any idle gap first. Because of this, a continuous stream of characters from a transmitter that runs a few percent fast or slow does not build up timing error from one character to the next.

A separate line monitor watches the synchronized level. It gives a one-cycle pulse when the line has been high for more than eleven bit times (idle), and another when it has been low for eleven bit times (break).

Top module: `serial_rx_resync`

## Requirements
- R1: Data bits are taken least significant bit first. The received byte appears on `rx_data` with `rx_valid` high for exactly one clock. That pulse follows the baud-enable pulse on which the stop bit is sampled, and back-to-back frames produce one strobe each.
- R2: A start is confirmed only when the line is still low on the 8th baud-enable pulse after the one that saw the falling level. A low pulse shorter than that produces no byte.
- R3: A stop bit sampled low gives `frame_err` = 1 with that byte's strobe. A stop bit sampled high gives `frame_err` = 0. `rx_data` and `frame_err` change only together with `rx_valid`.
- R4: After a framing error, no new start is taken until the line has been seen high. A low level that lasts 13 bit times therefore yields exactly one byte.
- R5: Start search resumes at the mid-stop sample. An unbroken stream of 40 characters from a transmitter about 3% faster than the receiver is received without loss or error.
- R6: An unbroken stream of 40 characters from a transmitter about 3% slower than the receiver is received without loss or error.
- R7: `idle_pulse` is high for one clock once per high run, when the line has been high for more than 11 bit times (177 baud-enable samples). A high run of 10 bit times gives no pulse.
- R8: `break_pulse` is high for one clock once per low run, when the line has been low for 11 bit times (176 samples). A low run of 10 bit times gives no pulse. Idle and break are never signalled together.
- R9: During and right after reset, `rx_valid`, `frame_err`, `idle_pulse` and `break_pulse` are 0, and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, high at rest |
| tick16 | input | 1 | One-cycle enable pulsing at 16x the bit rate |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| frame_err | output | 1 | Stop bit of the last byte was sampled low |
| idle_pulse | output | 1 | One-cycle pulse when the line has been high for more than 11 bit times |
| break_pulse | output | 1 | One-cycle pulse when the line has been low for 11 bit times |

## Verification
The assertions assume that `tick16` is a one-cycle strobe and that reset is held for at least one edge. No other input needs to be well formed, because framing, idle and break are all defined for any line pattern. The stimulus drives the baud enable on every fourth clock. It sets bit periods in clocks between 62 and 66, against a nominal 64, so the mid-bit samples stay well inside each bit. Framing errors, glitches and long low and high runs are placed directly so that the expected byte, idle and break counts for each phase are known in advance.

// File: rtl/rx_pkg.sv
package rx_pkg;

    localparam int unsigned OVERSAMPLE    = 16;
    localparam int unsigned CHAR_BITS     = 8;
    localparam int unsigned SYNC_DEPTH    = 2;
    localparam int unsigned IDLE_BIT_TIME = 11;
    localparam int unsigned BRK_BIT_TIME  = 11;

    typedef enum logic [2:0] {
        SEQ_HUNT,
        SEQ_START,
        SEQ_DATA,
        SEQ_STOP,
        SEQ_WAIT_HIGH
    } seq_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int unsigned STAGES = rx_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import rx_pkg::*;
#(
    parameter int unsigned OSR   = OVERSAMPLE,
    parameter int unsigned DBITS = CHAR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             line_s,
    output logic [DBITS-1:0] data_q,
    output logic             valid_q,
    output logic             ferr_q
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned BW = (DBITS > 1) ? $clog2(DBITS) : 1;
    localparam logic [CW-1:0] HALF_LAST = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(DBITS - 1);

    seq_state_e       state;
    logic [CW-1:0]    phase;
    logic [BW-1:0]    bit_idx;
    logic [DBITS-1:0] shifter;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_HUNT;
            phase   <= '0;
            bit_idx <= '0;
            shifter <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (tick) begin
                unique case (state)
                    SEQ_HUNT: begin
                        if (!line_s) begin
                            state <= SEQ_START;
                            phase <= '0;
                        end
                    end
                    SEQ_START: begin
                        if (phase == HALF_LAST) begin
                            phase   <= '0;
                            bit_idx <= '0;
                            state   <= line_s ? SEQ_HUNT : SEQ_DATA;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    SEQ_DATA: begin
                        if (phase == FULL_LAST) begin
                            phase   <= '0;
                            shifter <= {line_s, shifter[DBITS-1:1]};
                            if (bit_idx == BIT_LAST) state <= SEQ_STOP;
                            else bit_idx <= bit_idx + 1'b1;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    SEQ_STOP: begin
                        if (phase == FULL_LAST) begin
                            phase   <= '0;
                            valid_q <= 1'b1;
                            data_q  <= shifter;
                            ferr_q  <= ~line_s;
                            state   <= line_s ? SEQ_HUNT : SEQ_WAIT_HIGH;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    SEQ_WAIT_HIGH: begin
                        if (line_s) state <= SEQ_HUNT;
                    end
                    default: state <= SEQ_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_line_mon.sv
module rx_line_mon
    import rx_pkg::*;
#(
    parameter int unsigned OSR        = OVERSAMPLE,
    parameter int unsigned IDLE_BITS  = IDLE_BIT_TIME,
    parameter int unsigned BREAK_BITS = BRK_BIT_TIME
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_s,
    output logic idle_q,
    output logic brk_q
);
    localparam int unsigned IDLE_RUN = OSR * IDLE_BITS + 1;
    localparam int unsigned BRK_RUN  = OSR * BREAK_BITS;
    localparam int unsigned RUN_MAX  = max_u(IDLE_RUN, BRK_RUN);
    localparam int unsigned RW       = $clog2(RUN_MAX + 1);
    localparam logic [RW-1:0] IDLE_PRE = RW'(IDLE_RUN - 1);
    localparam logic [RW-1:0] BRK_PRE  = RW'(BRK_RUN - 1);
    localparam logic [RW-1:0] SAT      = RW'(RUN_MAX);

    logic          level;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            level  <= 1'b1;
            run    <= '0;
            idle_q <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            idle_q <= 1'b0;
            brk_q  <= 1'b0;
            if (tick) begin
                if (line_s != level) begin
                    level <= line_s;
                    run   <= RW'(1);
                end else begin
                    if (run != SAT) run <= run + 1'b1;
                    idle_q <= level  && (run == IDLE_PRE);
                    brk_q  <= !level && (run == BRK_PRE);
                end
            end
        end
    end
endmodule

// File: rtl/serial_rx_resync.sv
module serial_rx_resync
    import rx_pkg::*;
#(
    parameter int unsigned OSR         = OVERSAMPLE,
    parameter int unsigned DATA_BITS   = CHAR_BITS,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH,
    parameter int unsigned IDLE_BITS   = IDLE_BIT_TIME,
    parameter int unsigned BREAK_BITS  = BRK_BIT_TIME
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_in,
    input  logic                 tick16,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 frame_err,
    output logic                 idle_pulse,
    output logic                 break_pulse
);
    logic line_s;

    rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (line_s)
    );

    rx_frame #(.OSR(OSR), .DBITS(DATA_BITS)) i_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .line_s  (line_s),
        .data_q  (rx_data),
        .valid_q (rx_valid),
        .ferr_q  (frame_err)
    );

    rx_line_mon #(.OSR(OSR), .IDLE_BITS(IDLE_BITS), .BREAK_BITS(BREAK_BITS)) i_mon (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick16),
        .line_s (line_s),
        .idle_q (idle_pulse),
        .brk_q  (break_pulse)
    );
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
    parameter int unsigned DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick16,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 frame_err,
    input logic                 idle_pulse,
    input logic                 break_pulse
);
    assert_valid_single_R1: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_valid_after_tick_R1: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(tick16));

    assert_ferr_with_valid_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_err) |-> rx_valid);

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_data));

    assert_idle_single_R7: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |=> !idle_pulse);

    assert_break_single_R8: assert property (@(posedge clk) disable iff (rst)
        break_pulse |=> !break_pulse);

    assert_idle_break_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(idle_pulse && break_pulse));
endmodule

bind serial_rx_resync rx_checker #(.DATA_BITS(DATA_BITS)) i_rx_checker (
    .clk         (clk),
    .rst         (rst),
    .tick16      (tick16),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .frame_err   (frame_err),
    .idle_pulse  (idle_pulse),
    .break_pulse (break_pulse)
);

// File: tb/test_serial_rx_resync.sv
module test_serial_rx_resync;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, frame_err, idle_pulse, break_pulse;

    int n_chk = 0, n_fail = 0;
    int n_valid = 0, n_idle = 0, n_brk = 0;
    logic [8:0] exp_q[$];

    always #2 clk = ~clk;

    serial_rx_resync i_serial_rx_resync (
        .clk(clk), .rst(rst), .rx_in(rx_line), .tick16(tick),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
        .idle_pulse(idle_pulse), .break_pulse(break_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    initial begin : tick_gen
        int div = 0;
        forever begin
            @(negedge clk);
            tick = (div == 3);
            div = (div + 1) % 4;
        end
    end

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (idle_pulse) n_idle++;
                if (break_pulse) n_brk++;
                if (rx_valid) begin
                    n_valid++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected byte", int'(rx_data), -1);
                    end else begin
                        logic [8:0] e;
                        e = exp_q.pop_front();
                        chk(rx_data == e[8:1], "R1 data", int'(rx_data), int'(e[8:1]));
                        chk(frame_err == e[0], "R3 frame_err", int'(frame_err), int'(e[0]));
                    end
                end
            end
        end
    end

    task automatic hold(input logic lvl, input int bits, input int cpb);
        rx_line = lvl;
        repeat (bits * cpb) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop_ok, input int cpb);
        exp_q.push_back({b, ~stop_ok});
        hold(1'b0, 1, cpb);
        for (int i = 0; i < 8; i++) hold(b[i], 1, cpb);
        hold(stop_ok, 1, cpb);
        if (!stop_ok) hold(1'b1, 1, cpb);
    endtask

    function automatic int pick_cpb(input int sel);
        return 63 + (sel % 3);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        int v0, i0, b0;
        void'($urandom(32'd4242));
        repeat (6) @(negedge clk);
        // R9 reset state
        chk(rx_valid == 0 && frame_err == 0, "R9 valid/ferr in reset", int'({rx_valid, frame_err}), 0);
        chk(idle_pulse == 0 && break_pulse == 0, "R9 pulses in reset", int'({idle_pulse, break_pulse}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_data == 8'h00 && rx_valid == 0, "R9 after reset", int'(rx_data), 0);

        // R7 initial idle after a long high run
        hold(1'b1, 14, 64);
        chk(n_idle == 1, "R7 idle after 14 bits high", n_idle, 1);

        // R1 directed bytes back to back
        v0 = n_valid;
        send(8'h55, 1'b1, 64); send(8'hA3, 1'b1, 64); send(8'h00, 1'b1, 64);
        send(8'hFF, 1'b1, 64); send(8'h80, 1'b1, 64); send(8'h01, 1'b1, 64);
        hold(1'b1, 2, 64);
        chk(n_valid - v0 == 6, "R1 byte count", n_valid - v0, 6);

        // R2 glitch rejection
        v0 = n_valid;
        rx_line = 1'b0; repeat (20) @(negedge clk);
        hold(1'b1, 3, 64);
        chk(n_valid == v0, "R2 glitch gave no byte", n_valid - v0, 0);

        // R3 framing error then a good byte
        send(8'h3C, 1'b0, 64);
        send(8'h5A, 1'b1, 64);
        hold(1'b1, 2, 64);

        // R4/R8 long low: one byte, one break
        v0 = n_valid; b0 = n_brk;
        exp_q.push_back(9'h001);
        hold(1'b0, 13, 64);
        hold(1'b1, 2, 64);
        chk(n_valid - v0 == 1, "R4 one byte over long low", n_valid - v0, 1);
        chk(n_brk - b0 == 1, "R8 break on 13 bits low", n_brk - b0, 1);

        // R8 10-bit low gives no break; R7 10-bit high gives no idle
        b0 = n_brk; i0 = n_idle;
        exp_q.push_back(9'h001);
        hold(1'b0, 10, 64);
        hold(1'b1, 10, 64);
        chk(n_brk == b0, "R8 no break on 10 bits low", n_brk - b0, 0);
        chk(n_idle == i0, "R7 no idle on 10 bits high", n_idle - i0, 0);

        // R7 idle after frame and 13 bits high
        i0 = n_idle;
        send(8'h96, 1'b1, 64);
        hold(1'b1, 13, 64);
        chk(n_idle - i0 == 1, "R7 idle after 13 bits high", n_idle - i0, 1);

        // R5 fast transmitter stream
        v0 = n_valid;
        for (int k = 0; k < 40; k++) send(8'($urandom), 1'b1, 62);
        hold(1'b1, 3, 64);
        chk(n_valid - v0 == 40, "R5 fast stream count", n_valid - v0, 40);
        chk(exp_q.size() == 0, "R5 fast stream drained", exp_q.size(), 0);

        // R6 slow transmitter stream
        v0 = n_valid;
        for (int k = 0; k < 40; k++) send(8'($urandom), 1'b1, 66);
        hold(1'b1, 3, 64);
        chk(n_valid - v0 == 40, "R6 slow stream count", n_valid - v0, 40);
        chk(exp_q.size() == 0, "R6 slow stream drained", exp_q.size(), 0);

        // R1/R3 random mix
        i0 = n_idle; b0 = n_brk; v0 = n_valid;
        for (int k = 0; k < 30; k++) begin
            int cpb;
            cpb = pick_cpb(int'($urandom % 3));
            send(8'($urandom), ($urandom % 5) != 0, cpb);
            hold(1'b1, int'($urandom % 3), cpb);
        end
        hold(1'b1, 2, 64);
        chk(n_valid - v0 == 30, "R1 random count", n_valid - v0, 30);
        chk(n_idle == i0 && n_brk == b0, "R8 no idle/break in mix", (n_idle - i0) + (n_brk - b0), 0);
        chk(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);

        finish_run();
    end
endmodule